// File: doc/BRIEF.md
# Dual-Cluster Register Rename Map

This block renames the logical registers of an out-of-order core whose execution resources are split into two clusters. Each cluster has its own physical register file and its own free pool. A single map table serves both clusters. Each logical register can have a live physical copy in the first cluster, in the second, or in both. It is in both only after an inter-cluster copy has moved its value.

One instruction is renamed per cycle. The steering logic picks a target cluster, with help from the location vectors this block reports for each source. The block then allocates a destination register in that cluster and points the destination's entry only there. For every source that lives only in the other cluster, it asks dispatch to insert a copy into a freshly allocated register of the target cluster. The map then records the source as living in both clusters. The mapping that the destination had before this instruction is handed out so that it can travel with the instruction. At commit that previous mapping is released. On a flush, instructions are unwound youngest first, one per cycle, and each one's previous mapping is put back.

Copy operations are treated as independent of the instruction that caused them. Once requested they always complete, even if that instruction is later flushed. The copy therefore stays a valid second mapping of its source.

Top module: `rmap_rename`

## Requirements
- R1: After reset, logical register i is mapped only in cluster 1, to physical register i. Cluster 1 holds physical registers NUM_LREG and upward as free. Every register of cluster 2 is free.
- R2: For each source, the 2-bit location output reports where that logical register is mapped before the current instruction is applied. Bit 0 means cluster 1 and bit 1 means cluster 2. The target cluster input uses 0 for cluster 1 and 1 for cluster 2.
- R3: A renamed instruction with a destination gets the lowest-numbered free register of its target cluster that the copies have not already taken. Registers are handed out in this order: copy for source 0, then copy for source 1, then destination. Afterwards the destination's entry maps only to the new register.
- R4: The old-mapping outputs give the destination entry's location vector and its physical register in each cluster. The values are taken after any copy made in the same cycle for that same logical register.
- R5: A used source that is mapped only in the other cluster raises a copy request on that source's channel. The request carries the source's register in the other cluster and a newly allocated register in the target cluster. The logical register is then mapped in both clusters.
- R6: When both sources name the same logical register and it needs a copy, only channel 0 raises a request. Both sources then read the register that copy allocated.
- R7: Each used source's physical register output names its register in the target cluster. That is either the existing mapping or the register allocated for its copy.
- R8: The rename ready output is low when the target cluster has fewer free registers than the copies plus destination need. A stalled instruction changes neither the map nor the free pools.
- R9: A commit returns every physical register of the committed instruction's previous mapping to its cluster's pool. A dual mapping therefore frees one register in each cluster.
- R10: While a flush is presented, rename ready is low. The flushed destination's entry is restored to the supplied previous mapping. Every register currently mapped for that logical register goes back to its pool, including registers placed there by copies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ren_valid | input | 1 | Instruction presented for rename |
| ren_cluster | input | 1 | Target cluster (0 = cluster 1, 1 = cluster 2) |
| ren_has_dst | input | 1 | Instruction writes a register |
| ren_dst | input | LW | Destination logical register |
| ren_src0_use | input | 1 | Source 0 is a register operand |
| ren_src0 | input | LW | Source 0 logical register |
| ren_src1_use | input | 1 | Source 1 is a register operand |
| ren_src1 | input | LW | Source 1 logical register |
| ren_ready | output | 1 | Rename can accept the presented instruction |
| src0_loc | output | 2 | Location vector of source 0 |
| src1_loc | output | 2 | Location vector of source 1 |
| src0_preg | output | PW | Source 0 physical register in target cluster |
| src1_preg | output | PW | Source 1 physical register in target cluster |
| dst_preg | output | PW | Allocated destination register |
| old_loc | output | 2 | Previous location vector of the destination |
| old_preg_a | output | PW | Previous cluster 1 register of the destination |
| old_preg_b | output | PW | Previous cluster 2 register of the destination |
| copy_valid | output | 2 | Copy request per source channel |
| copy_to_cluster | output | 1 | Cluster receiving the copies |
| copy_src_preg | output | 2xPW | Register read by each copy in the other cluster |
| copy_dst_preg | output | 2xPW | Register written by each copy |
| commit_valid | input | 1 | Oldest instruction commits |
| commit_old_loc | input | 2 | Its previous location vector |
| commit_old_preg_a | input | PW | Its previous cluster 1 register |
| commit_old_preg_b | input | PW | Its previous cluster 2 register |
| flush_valid | input | 1 | Youngest instruction is flushed |
| flush_has_dst | input | 1 | Flushed instruction wrote a register |
| flush_dst | input | LW | Flushed destination logical register |
| flush_old_loc | input | 2 | Location vector to restore |
| flush_old_preg_a | input | PW | Cluster 1 register to restore |
| flush_old_preg_b | input | PW | Cluster 2 register to restore |

## Verification
The bench builds the block with four logical registers and eight physical registers per cluster. Cluster 1 therefore starts with only four free registers, and a handful of renames drain it. This makes the stall, and the reuse of registers freed by commit and flush, reachable in a short sequence. The narrow tag space also makes it easy to steer a source and a destination to the same logical register. The bench uses this to exercise same-cycle copy and overwrite, repeated sources, and the unwinding of a dual mapping whose copy register has to be reclaimed.

// File: rtl/rmap_pkg.sv
// Shared definitions for the dual-cluster rename map.
// Assumes exactly two clusters; location vectors carry one bit per cluster.
package rmap_pkg;
    localparam int NCL       = 2;   // clusters
    localparam int MAX_ALLOC = 3;   // registers one rename may take: two copies + destination

    typedef logic [NCL-1:0] loc_t;

    // One-hot location vector for a cluster index (0 = cluster 1).
    function automatic loc_t loc_of(input logic cl);
        return cl ? 2'b10 : 2'b01;
    endfunction
endpackage

// File: rtl/rmap_freelist.sv
// Bitmap free pool for one cluster's physical register file.
// Offers the lowest free registers as up to MAX_ALLOC picks each cycle.
// The first alloc_cnt picks are removed, and every bit in rel_mask is returned.
// Assumes the caller never releases a register that is already free.
module rmap_freelist #(
    parameter int NPREG = 8,
    parameter int NRESV = 0,
    localparam int PW    = $clog2(NPREG),
    localparam int NPICK = rmap_pkg::MAX_ALLOC,
    localparam int CW    = $clog2(NPICK + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [CW-1:0]               alloc_cnt,
    input  logic [NPREG-1:0]            rel_mask,
    output logic [NPICK-1:0][PW-1:0]    pick,
    output logic [CW-1:0]               avail
);
    logic [NPREG-1:0] free_q;
    logic [NPREG-1:0] take_mask;

    // Scan for the lowest free registers, saturating at NPICK.
    always_comb begin
        int n;
        n    = 0;
        pick = '0;
        for (int i = 0; i < NPREG; i++) begin
            if (free_q[i] && n < NPICK) begin
                pick[n] = PW'(i);
                n = n + 1;
            end
        end
        avail = CW'(n);
    end

    // Build the mask of registers handed out this cycle.
    always_comb begin
        take_mask = '0;
        for (int k = 0; k < NPICK; k++) begin
            if (CW'(k) < alloc_cnt) take_mask[pick[k]] = 1'b1;
        end
    end

    // Pool state: reserved registers start busy, the rest free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NPREG; i++) free_q[i] <= (i >= NRESV);
        end else begin
            free_q <= (free_q & ~take_mask) | rel_mask;
        end
    end

    a_r8_alloc_within_avail: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_cnt <= avail);

    a_r9_release_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_mask & free_q) == '0);
endmodule

// File: rtl/rmap_table.sv
// Storage of the logical-to-physical map, one entry per logical register.
// Each entry holds a location vector and one physical tag per cluster.
// NRD combinational read ports. NWR write ports of whole entries, where a later port wins on the same index.
// At reset every register i maps to physical register i of cluster 1.
module rmap_table #(
    parameter int NLREG = 4,
    parameter int NPREG = 8,
    parameter int NRD   = 3,
    parameter int NWR   = 3,
    localparam int LW   = $clog2(NLREG),
    localparam int PW   = $clog2(NPREG)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NRD-1:0][LW-1:0]            rd_idx,
    output logic [NRD-1:0][1:0]               rd_loc,
    output logic [NRD-1:0][1:0][PW-1:0]       rd_p,
    input  logic [NWR-1:0]                    wr_en,
    input  logic [NWR-1:0][LW-1:0]            wr_idx,
    input  logic [NWR-1:0][1:0]               wr_loc,
    input  logic [NWR-1:0][1:0][PW-1:0]       wr_p
);
    logic [NLREG-1:0][1:0]          ent_loc;
    logic [NLREG-1:0][1:0][PW-1:0]  ent_p;

    // Read ports, one per requested index.
    generate
        for (genvar r = 0; r < NRD; r++) begin : g_rd
            assign rd_loc[r] = ent_loc[rd_idx[r]];
            assign rd_p[r]   = ent_p[rd_idx[r]];
        end
    endgenerate

    // Entry update: reset mapping, then write ports in increasing priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NLREG; i++) begin
                ent_loc[i]  <= 2'b01;
                ent_p[i][0] <= PW'(i);
                ent_p[i][1] <= '0;
            end
        end else begin
            for (int w = 0; w < NWR; w++) begin
                if (wr_en[w]) begin
                    ent_loc[wr_idx[w]] <= wr_loc[w];
                    ent_p[wr_idx[w]]   <= wr_p[w];
                end
            end
        end
    end

    generate
        for (genvar g = 0; g < NLREG; g++) begin : g_chk
            a_r1_entry_never_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
                ent_loc[g] != 2'b00);
        end
    endgenerate
endmodule

// File: rtl/rmap_rename.sv
// Dual-cluster rename map: one rename, one commit and one flush per cycle.
// The steering block supplies the target cluster. This block allocates, requests copies for
// sources mapped only in the other cluster, and reports the destination's previous mapping.
// Assumes flushes arrive youngest first, rename is held off while they do, and requested
// copies always complete even if their requester is flushed.
module rmap_rename #(
    parameter int NUM_LREG = 4,
    parameter int NUM_PREG = 8,
    localparam int LW    = $clog2(NUM_LREG),
    localparam int PW    = $clog2(NUM_PREG),
    localparam int NPICK = rmap_pkg::MAX_ALLOC,
    localparam int CW    = $clog2(NPICK + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ren_valid,
    input  logic                 ren_cluster,
    input  logic                 ren_has_dst,
    input  logic [LW-1:0]        ren_dst,
    input  logic                 ren_src0_use,
    input  logic [LW-1:0]        ren_src0,
    input  logic                 ren_src1_use,
    input  logic [LW-1:0]        ren_src1,
    output logic                 ren_ready,
    output logic [1:0]           src0_loc,
    output logic [1:0]           src1_loc,
    output logic [PW-1:0]        src0_preg,
    output logic [PW-1:0]        src1_preg,
    output logic [PW-1:0]        dst_preg,
    output logic [1:0]           old_loc,
    output logic [PW-1:0]        old_preg_a,
    output logic [PW-1:0]        old_preg_b,
    output logic [1:0]           copy_valid,
    output logic                 copy_to_cluster,
    output logic [1:0][PW-1:0]   copy_src_preg,
    output logic [1:0][PW-1:0]   copy_dst_preg,
    input  logic                 commit_valid,
    input  logic [1:0]           commit_old_loc,
    input  logic [PW-1:0]        commit_old_preg_a,
    input  logic [PW-1:0]        commit_old_preg_b,
    input  logic                 flush_valid,
    input  logic                 flush_has_dst,
    input  logic [LW-1:0]        flush_dst,
    input  logic [1:0]           flush_old_loc,
    input  logic [PW-1:0]        flush_old_preg_a,
    input  logic [PW-1:0]        flush_old_preg_b
);
    import rmap_pkg::*;

    localparam int NRD = 3;
    localparam int NWR = 3;

    logic                            tgt, oth;
    logic [NRD-1:0][LW-1:0]          rd_idx;
    logic [NRD-1:0][1:0]             rd_loc;
    logic [NRD-1:0][1:0][PW-1:0]     rd_p;
    logic [NWR-1:0]                  wr_en;
    logic [NWR-1:0][LW-1:0]          wr_idx;
    logic [NWR-1:0][1:0]             wr_loc;
    logic [NWR-1:0][1:0][PW-1:0]     wr_p;

    logic [NCL-1:0][CW-1:0]          fl_alloc;
    logic [NCL-1:0][NUM_PREG-1:0]    fl_rel;
    logic [NCL-1:0][NPICK-1:0][PW-1:0] fl_pick;
    logic [NCL-1:0][CW-1:0]          fl_avail;

    logic             need0, need1_raw, need1, dup;
    logic [CW-1:0]    nalloc, slot1, slot2;
    logic             fire;
    logic [PW-1:0]    cp0_p, cp1_p, new_p;

    assign tgt = ren_cluster;
    assign oth = ~ren_cluster;

    // Per-cluster free pools; cluster 1 starts with the architectural registers busy.
    generate
        for (genvar c = 0; c < NCL; c++) begin : g_fl
            rmap_freelist #(
                .NPREG (NUM_PREG),
                .NRESV ((c == 0) ? NUM_LREG : 0)
            ) u_fl (
                .clk       (clk),
                .rst_n     (rst_n),
                .alloc_cnt (fl_alloc[c]),
                .rel_mask  (fl_rel[c]),
                .pick      (fl_pick[c]),
                .avail     (fl_avail[c])
            );
        end
    endgenerate

    rmap_table #(
        .NLREG (NUM_LREG),
        .NPREG (NUM_PREG),
        .NRD   (NRD),
        .NWR   (NWR)
    ) u_tab (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (rd_idx),
        .rd_loc (rd_loc),
        .rd_p   (rd_p),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_loc (wr_loc),
        .wr_p   (wr_p)
    );

    // Table read addresses: both sources, and the destination or the flushed register.
    always_comb begin
        rd_idx[0] = ren_src0;
        rd_idx[1] = ren_src1;
        rd_idx[2] = flush_valid ? flush_dst : ren_dst;
    end

    // Copy detection and the register demand of this rename.
    always_comb begin
        need0     = ren_src0_use && !rd_loc[0][tgt];
        need1_raw = ren_src1_use && !rd_loc[1][tgt];
        dup       = need0 && need1_raw && (ren_src1 == ren_src0);
        need1     = need1_raw && !dup;
        nalloc    = CW'(need0) + CW'(need1) + CW'(ren_has_dst);
        ren_ready = !flush_valid && (fl_avail[tgt] >= nalloc);
        fire      = ren_valid && ren_ready;
    end

    // Hand out the target pool's picks in the order copy0, copy1, destination.
    always_comb begin
        slot1 = need0 ? CW'(1) : CW'(0);
        slot2 = slot1 + CW'(need1);
        cp0_p = fl_pick[tgt][0];
        cp1_p = fl_pick[tgt][slot1];
        new_p = fl_pick[tgt][slot2];
    end

    // Source reporting and copy requests.
    always_comb begin
        src0_loc            = rd_loc[0];
        src1_loc            = rd_loc[1];
        src0_preg           = need0 ? cp0_p : rd_p[0][tgt];
        src1_preg           = need1 ? cp1_p : (dup ? cp0_p : rd_p[1][tgt]);
        dst_preg            = new_p;
        copy_valid          = {fire && need1, fire && need0};
        copy_to_cluster     = tgt;
        copy_src_preg[0]    = rd_p[0][oth];
        copy_src_preg[1]    = rd_p[1][oth];
        copy_dst_preg[0]    = cp0_p;
        copy_dst_preg[1]    = cp1_p;
    end

    // Previous mapping of the destination, including same-cycle copies into it.
    always_comb begin
        logic [1:0][PW-1:0] op;
        op      = rd_p[2];
        old_loc = rd_loc[2];
        if (need0 && ren_src0 == ren_dst) begin
            old_loc = old_loc | loc_of(tgt);
            op[tgt] = cp0_p;
        end
        if (need1 && ren_src1 == ren_dst) begin
            old_loc = old_loc | loc_of(tgt);
            op[tgt] = cp1_p;
        end
        old_preg_a = op[0];
        old_preg_b = op[1];
    end

    // Map writes: copy0, copy1, then destination or flush restore (highest priority).
    always_comb begin
        wr_en     = '0;
        wr_idx[0] = ren_src0;
        wr_loc[0] = rd_loc[0] | loc_of(tgt);
        wr_p[0]   = rd_p[0];
        wr_p[0][tgt] = cp0_p;
        wr_en[0]  = fire && need0;

        wr_idx[1] = ren_src1;
        wr_loc[1] = rd_loc[1] | loc_of(tgt);
        wr_p[1]   = rd_p[1];
        wr_p[1][tgt] = cp1_p;
        wr_en[1]  = fire && need1;

        wr_idx[2] = ren_dst;
        wr_loc[2] = loc_of(tgt);
        wr_p[2]   = '0;
        wr_p[2][tgt] = new_p;
        wr_en[2]  = fire && ren_has_dst;
        if (flush_valid && flush_has_dst) begin
            wr_en[2]  = 1'b1;
            wr_idx[2] = flush_dst;
            wr_loc[2] = flush_old_loc;
            wr_p[2]   = {flush_old_preg_b, flush_old_preg_a};
        end
    end

    // Pool traffic: allocation in the target, releases from commit and flush.
    always_comb begin
        fl_alloc      = '0;
        fl_alloc[tgt] = fire ? nalloc : '0;
        fl_rel        = '0;
        if (commit_valid) begin
            if (commit_old_loc[0]) fl_rel[0][commit_old_preg_a] = 1'b1;
            if (commit_old_loc[1]) fl_rel[1][commit_old_preg_b] = 1'b1;
        end
        if (flush_valid && flush_has_dst) begin
            for (int c = 0; c < NCL; c++) begin
                if (rd_loc[2][c]) fl_rel[c][rd_p[2][c]] = 1'b1;
            end
        end
    end

    a_r10_flush_blocks_rename: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |-> !ren_ready);

    a_r5_copy_regs_distinct: assert property (@(posedge clk) disable iff (!rst_n)
        (copy_valid == 2'b11) |-> (copy_dst_preg[0] != copy_dst_preg[1]));

    a_r3_dst_not_copy_reg: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_valid && ren_ready && ren_has_dst && copy_valid[0]) |-> (dst_preg != copy_dst_preg[0]));

    a_r6_single_copy_for_repeat: assert property (@(posedge clk) disable iff (!rst_n)
        (copy_valid[0] && ren_src1_use && ren_src1 == ren_src0) |-> !copy_valid[1]);
endmodule

// File: tb/tb_rmap_rename.sv
`timescale 1ns/1ps
module tb_rmap_rename;
    localparam int NL = 4;
    localparam int NP = 8;
    localparam int LW = $clog2(NL);
    localparam int PW = $clog2(NP);

    logic clk = 1'b0, rst_n = 1'b0;
    always #4 clk = ~clk;

    logic ren_valid = 0, ren_cluster = 0, ren_has_dst = 0, ren_src0_use = 0, ren_src1_use = 0;
    logic [LW-1:0] ren_dst = 0, ren_src0 = 0, ren_src1 = 0;
    logic ren_ready;
    logic [1:0] src0_loc, src1_loc, old_loc, copy_valid;
    logic [PW-1:0] src0_preg, src1_preg, dst_preg, old_preg_a, old_preg_b;
    logic copy_to_cluster;
    logic [1:0][PW-1:0] copy_src_preg, copy_dst_preg;
    logic commit_valid = 0;
    logic [1:0] commit_old_loc = 0;
    logic [PW-1:0] commit_old_preg_a = 0, commit_old_preg_b = 0;
    logic flush_valid = 0, flush_has_dst = 0;
    logic [LW-1:0] flush_dst = 0;
    logic [1:0] flush_old_loc = 0;
    logic [PW-1:0] flush_old_preg_a = 0, flush_old_preg_b = 0;

    rmap_rename #(.NUM_LREG(NL), .NUM_PREG(NP)) dut (.*);

    typedef struct {
        int ready; int s0loc; int s1loc; int s0p; int s1p;
        int cpv; int cps0; int cps1; int cpd0; int cpd1;
        int dstp; int oloc; int oa; int ob; string req;
    } exp_t;
    typedef struct { int l; int loc; int a; int b; } rob_t;

    exp_t exq[$];
    rob_t rob[$];
    event drv_ev;
    int checks = 0, errors = 0;
    bit done = 0;

    int m_loc [NL];
    int m_p   [NL][2];
    logic [NP-1:0] m_free [2];

    task automatic chk(input string what, input string req, input int act, input int exp);
        if (exp < 0) return;
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int lowest(input logic [NP-1:0] m);
        for (int i = 0; i < NP; i++) if (m[i]) return i;
        return -1;
    endfunction

    task automatic idle();
        ren_valid = 0; ren_has_dst = 0; ren_src0_use = 0; ren_src1_use = 0;
        commit_valid = 0; flush_valid = 0; flush_has_dst = 0;
    endtask

    // Driver: compute the expected response from the bench model, drive, queue it.
    task automatic do_ren(input int cl, input int hd, input int d, input int u0, input int s0,
                          input int u1, input int s1, input string req);
        exp_t e;
        int n0, n1r, n1, dup, na, oth, tb, cp0, cp1, dp;
        logic [NP-1:0] tmp;
        oth = 1 - cl; tb = 1 << cl;
        n0  = (u0 != 0 && (m_loc[s0] & tb) == 0) ? 1 : 0;
        n1r = (u1 != 0 && (m_loc[s1] & tb) == 0) ? 1 : 0;
        dup = (n0 != 0 && n1r != 0 && s0 == s1) ? 1 : 0;
        n1  = (n1r != 0 && dup == 0) ? 1 : 0;
        na  = n0 + n1 + hd;
        e.ready = ($countones(m_free[cl]) >= na) ? 1 : 0;
        e.s0loc = m_loc[s0]; e.s1loc = m_loc[s1];
        tmp = m_free[cl]; cp0 = -1; cp1 = -1; dp = -1;
        if (n0 != 0) begin cp0 = lowest(tmp); tmp[cp0] = 1'b0; end
        if (n1 != 0) begin cp1 = lowest(tmp); tmp[cp1] = 1'b0; end
        if (hd != 0) dp = lowest(tmp);
        e.s0p = -1; e.s1p = -1; e.cps0 = -1; e.cps1 = -1; e.cpd0 = -1; e.cpd1 = -1;
        e.dstp = -1; e.oloc = -1; e.oa = -1; e.ob = -1; e.cpv = -1; e.req = req;
        if (e.ready != 0) begin
            e.cpv = (n1 << 1) | n0;
            if (u0 != 0) e.s0p = (n0 != 0) ? cp0 : m_p[s0][cl];
            if (u1 != 0) e.s1p = (n1 != 0) ? cp1 : (dup != 0) ? cp0 : m_p[s1][cl];
            if (n0 != 0) begin e.cps0 = m_p[s0][oth]; e.cpd0 = cp0;
                m_loc[s0] = m_loc[s0] | tb; m_p[s0][cl] = cp0; m_free[cl][cp0] = 1'b0; end
            if (n1 != 0) begin e.cps1 = m_p[s1][oth]; e.cpd1 = cp1;
                m_loc[s1] = m_loc[s1] | tb; m_p[s1][cl] = cp1; m_free[cl][cp1] = 1'b0; end
            if (hd != 0) begin
                e.dstp = dp; e.oloc = m_loc[d];
                if ((m_loc[d] & 1) != 0) e.oa = m_p[d][0];
                if ((m_loc[d] & 2) != 0) e.ob = m_p[d][1];
                rob.push_back('{d, m_loc[d], m_p[d][0], m_p[d][1]});
                m_loc[d] = tb; m_p[d][cl] = dp; m_free[cl][dp] = 1'b0;
            end
        end
        @(negedge clk);
        idle();
        ren_valid = 1; ren_cluster = cl[0]; ren_has_dst = hd[0]; ren_dst = d[LW-1:0];
        ren_src0_use = u0[0]; ren_src0 = s0[LW-1:0]; ren_src1_use = u1[0]; ren_src1 = s1[LW-1:0];
        exq.push_back(e);
        -> drv_ev;
        @(posedge clk);
    endtask

    task automatic do_commit();
        rob_t r;
        r = rob.pop_front();
        if ((r.loc & 1) != 0) m_free[0][r.a] = 1'b1;
        if ((r.loc & 2) != 0) m_free[1][r.b] = 1'b1;
        @(negedge clk);
        idle();
        commit_valid = 1; commit_old_loc = r.loc[1:0];
        commit_old_preg_a = r.a[PW-1:0]; commit_old_preg_b = r.b[PW-1:0];
        @(posedge clk);
    endtask

    // Flush the youngest renamed instruction while a rename is also presented.
    task automatic do_flush();
        rob_t r;
        exp_t e;
        r = rob.pop_back();
        for (int c = 0; c < 2; c++) if ((m_loc[r.l] & (1 << c)) != 0) m_free[c][m_p[r.l][c]] = 1'b1;
        m_loc[r.l] = r.loc; m_p[r.l][0] = r.a; m_p[r.l][1] = r.b;
        e = '{0, -1, -1, -1, -1, -1, -1, -1, -1, -1, -1, -1, -1, -1, "R10 rename held"};
        @(negedge clk);
        idle();
        flush_valid = 1; flush_has_dst = 1; flush_dst = r.l[LW-1:0]; flush_old_loc = r.loc[1:0];
        flush_old_preg_a = r.a[PW-1:0]; flush_old_preg_b = r.b[PW-1:0];
        ren_valid = 1; ren_cluster = 0;
        exq.push_back(e);
        -> drv_ev;
        @(posedge clk);
    endtask

    // Monitor: pop each expected item and compare away from the clock edge.
    initial begin
        forever begin
            exp_t e;
            @(drv_ev);
            #1;
            e = exq.pop_front();
            chk("ready",  e.req, int'(ren_ready), e.ready);
            chk("src0_loc", e.req, int'(src0_loc), e.s0loc);
            chk("src1_loc", e.req, int'(src1_loc), e.s1loc);
            chk("src0_preg", e.req, int'(src0_preg), e.s0p);
            chk("src1_preg", e.req, int'(src1_preg), e.s1p);
            chk("copy_valid", e.req, int'(copy_valid), e.cpv);
            chk("copy0_src", e.req, int'(copy_src_preg[0]), e.cps0);
            chk("copy1_src", e.req, int'(copy_src_preg[1]), e.cps1);
            chk("copy0_dst", e.req, int'(copy_dst_preg[0]), e.cpd0);
            chk("copy1_dst", e.req, int'(copy_dst_preg[1]), e.cpd1);
            chk("dst_preg", e.req, int'(dst_preg), e.dstp);
            chk("old_loc", e.req, int'(old_loc), e.oloc);
            chk("old_preg_a", e.req, int'(old_preg_a), e.oa);
            chk("old_preg_b", e.req, int'(old_preg_b), e.ob);
        end
    end

    initial begin
        #(8 * 5000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NL; i++) begin m_loc[i] = 1; m_p[i][0] = i; m_p[i][1] = 0; end
        m_free[0] = '0;
        for (int i = NL; i < NP; i++) m_free[0][i] = 1'b1;
        m_free[1] = '1;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;

        // R1 R2 R7: reset mapping seen through source lookups
        do_ren(0, 0, 0, 1, 0, 1, 3, "R1 R2 R7 reset map");
        // R3 R4 R5: copy into cluster 2 and destination there
        do_ren(1, 1, 1, 1, 0, 0, 0, "R3 R4 R5 copy and alloc");
        // R6: same source twice, one copy into cluster 1
        do_ren(0, 1, 2, 1, 1, 1, 1, "R6 repeated source");
        // R4 R7: dual-mapped source, overwrite of a dual mapping
        do_ren(1, 1, 0, 1, 0, 0, 0, "R4 R7 dual old mapping");
        // R3 R5: copy for source 1 only, destination drains cluster 1
        do_ren(0, 1, 3, 1, 3, 1, 0, "R3 R5 drain cluster 1");
        // R8: cluster 1 empty, rename must stall
        do_ren(0, 1, 1, 0, 0, 0, 0, "R8 stall");
        // R8 stalled rename left pool and map alone; cluster 2 still renames
        do_ren(1, 0, 0, 1, 3, 0, 0, "R8 no side effect");
        // R9: commits free previous registers, next rename reuses them
        do_commit();
        do_commit();
        do_ren(0, 1, 1, 0, 0, 0, 0, "R9 reuse after commit");
        // R10: unwind youngest first, restoring dual mappings
        do_flush();
        do_ren(0, 0, 0, 1, 1, 0, 0, "R10 restored dual");
        do_flush();
        do_flush();
        do_ren(0, 0, 0, 1, 0, 1, 3, "R10 restored after unwind");
        do_ren(0, 1, 3, 0, 0, 0, 0, "R10 freed regs reused");
        do_ren(1, 1, 2, 1, 0, 0, 0, "R10 freed cluster 2 reg");

        @(negedge clk);
        idle();
        repeat (2) @(posedge clk);
        #2;
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule